// File: doc/BRIEF.md
# Conversion Auto-Trigger Selector

This block decides when a data converter starts its next conversion without software involvement. A select field picks one of eight trigger conditions. Seven of them are event flags from neighbouring peripherals: the analog comparator, external interrupt 0, the two timer 0 events and the three timer 1 events. The eighth is the converter's own completion flag, which gives free-running operation. When the chosen condition goes from low to high, the block issues a start pulse to the conversion sequencer. That pulse lasts exactly one clock.

Edges are detected after the source multiplexer, not on each flag. Changing the select from a source whose flag is low to one whose flag is high therefore counts as an edge in its own right. The one exception is a change into free-running mode. That change never produces a start, even when the completion flag is already high.

All pins are plain level control signals. No data stream flows through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `ats_trigger_sel`

## Requirements
- R1: `src_sel` picks the trigger source. 0 selects `conv_done`. A value k from 1 to 7 selects `evt_flags[k-1]`, where bit 0 is the comparator, bit 1 is external interrupt 0, bit 2 is timer 0 compare, bit 3 is timer 0 overflow, bit 4 is timer 1 compare B, bit 5 is timer 1 overflow and bit 6 is timer 1 capture.
- R2: A low-to-high change of the selected source gives `start_conv` high for exactly one cycle. A source that stays high gives no further pulse.
- R3: While `auto_en` is low, `start_conv` stays low whatever the select and flag values are.
- R4: While `conv_en` is low, `start_conv` stays low.
- R5: Changing `src_sel` from a source that was low in the previous cycle to a source that is high now gives a start pulse when both enables are set.
- R6: In the cycle in which `src_sel` becomes 0 from a nonzero value, `start_conv` stays low, even if `conv_done` is high.
- R7: In free-running mode (`src_sel` = 0), each rising edge of `conv_done` gives one start pulse.
- R8: `start_conv` is low while `rst_n` is low. Reset clears the stored source history, so a selected source that is high in the first cycle after reset counts as a rising edge.
- R9: Edges on flags that are not selected do not affect `start_conv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 3 | Trigger source select |
| auto_en | input | 1 | Auto-trigger enable |
| conv_en | input | 1 | Converter enable |
| conv_done | input | 1 | Converter completion flag |
| evt_flags | input | 7 | Peripheral event flags |
| start_conv | output | 1 | One-cycle start pulse to the sequencer |

## Verification
The assertions check four rules on every cycle: a start is never issued without both enables, two starts never occur back to back, every start coincides with a high level on the selected source, and a start is never issued in the cycle that enters free-running mode. Other behaviours need the history of earlier inputs, and only the bench scenarios can show them. These are that an edge really produces a pulse, that reselecting from a low source to a high source triggers, that an edge on an unselected flag is ignored, and that the history is clear after reset.

// File: rtl/ats_pkg.sv
package ats_pkg;
  // Number of peripheral event flags feeding the selector
  localparam int unsigned EVT_N = 7;
  // Select width covers the event flags plus the free-running code
  localparam int unsigned SEL_W = $clog2(EVT_N + 1);
  // Code that selects the converter completion flag
  localparam logic [SEL_W-1:0] SEL_FREE_RUN = '0;
endpackage

// File: rtl/ats_src_mux.sv
module ats_src_mux #(
  parameter int unsigned EVT_N = ats_pkg::EVT_N,
  parameter int unsigned SEL_W = ats_pkg::SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             done_flag,
  input  logic [EVT_N-1:0] evts,
  output logic             src
);
  localparam int unsigned CAND_N = EVT_N + 1;

  logic [CAND_N-1:0] cand;

  // Candidate 0 is the completion flag; candidates 1..EVT_N are the events
  assign cand[0] = done_flag;
  for (genvar g = 1; g < CAND_N; g++) begin : g_cand
    assign cand[g] = evts[g-1];
  end

  always_comb begin
    src = 1'b0;
    for (int i = 0; i < CAND_N; i++) begin
      if (sel == SEL_W'(i)) src = cand[i];
    end
  end
endmodule

// File: rtl/ats_sel_track.sv
module ats_sel_track #(
  parameter int unsigned SEL_W = ats_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             entering_fr
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= ats_pkg::SEL_FREE_RUN;
    else        sel_q <= sel;
  end

  // High only in the cycle the select moves into free-running mode
  assign entering_fr = (sel == ats_pkg::SEL_FREE_RUN) &&
                       (sel_q != ats_pkg::SEL_FREE_RUN);
endmodule

// File: rtl/ats_edge_det.sv
module ats_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic suppress,
  output logic rise
);
  logic src_q;
  logic ref_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) src_q <= 1'b0;
    else        src_q <= src;
  end

  // When suppressed, the reference is forced to the current level: no edge
  assign ref_lvl = suppress ? src : src_q;
  assign rise    = src & ~ref_lvl;
endmodule

// File: rtl/ats_trigger_sel.sv
module ats_trigger_sel #(
  parameter int unsigned EVT_N = ats_pkg::EVT_N,
  parameter int unsigned SEL_W = ats_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             auto_en,
  input  logic             conv_en,
  input  logic             conv_done,
  input  logic [EVT_N-1:0] evt_flags,
  output logic             start_conv
);
  logic muxed;
  logic entering_fr;
  logic rise;

  ats_src_mux #(.EVT_N(EVT_N), .SEL_W(SEL_W)) u_mux (
    .sel       (src_sel),
    .done_flag (conv_done),
    .evts      (evt_flags),
    .src       (muxed)
  );

  ats_sel_track #(.SEL_W(SEL_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (src_sel),
    .entering_fr (entering_fr)
  );

  ats_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (muxed),
    .suppress (entering_fr),
    .rise     (rise)
  );

  assign start_conv = rst_n & auto_en & conv_en & rise;
endmodule

// File: rtl/ats_trigger_sel_chk.sv
module ats_trigger_sel_chk #(
  parameter int unsigned EVT_N = ats_pkg::EVT_N,
  parameter int unsigned SEL_W = ats_pkg::SEL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] src_sel,
  input logic             auto_en,
  input logic             conv_en,
  input logic             conv_done,
  input logic [EVT_N-1:0] evt_flags,
  input logic             start_conv
);
  // R3
  start_needs_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |-> auto_en);

  // R4
  start_needs_conv_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |-> conv_en);

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |=> !start_conv);

  // R6
  fr_entry_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == '0 && $past(src_sel) != '0) |-> !start_conv);

  // R1
  fr_source_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_conv && src_sel == '0) |-> conv_done);

  // R1
  evt_source_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_conv && src_sel != '0) |-> evt_flags[src_sel - SEL_W'(1)]);
endmodule

bind ats_trigger_sel ats_trigger_sel_chk #(.EVT_N(EVT_N), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_sel    (src_sel),
  .auto_en    (auto_en),
  .conv_en    (conv_en),
  .conv_done  (conv_done),
  .evt_flags  (evt_flags),
  .start_conv (start_conv)
);

// File: tb/ats_trigger_sel_bench.sv
module ats_trigger_sel_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] src_sel = '0;
  logic       auto_en = 1'b0;
  logic       conv_en = 1'b0;
  logic       conv_done = 1'b0;
  logic [6:0] evt_flags = '0;
  logic       start_conv;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Model state: previous selected level and previous select
  logic       m_prev = 1'b0;
  logic [2:0] m_psel = '0;

  always #10 clk = ~clk;

  ats_trigger_sel u_ats_trigger_sel (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .auto_en(auto_en),
    .conv_en(conv_en), .conv_done(conv_done), .evt_flags(evt_flags),
    .start_conv(start_conv)
  );

  function automatic logic sel_level(logic [2:0] s, logic d, logic [6:0] e);
    return (s == 3'd0) ? d : e[s - 3'd1];
  endfunction

  function automatic logic exp_start(logic [2:0] s, logic a, logic c, logic d,
                                     logic [6:0] e, logic pv, logic [2:0] ps);
    logic lvl;
    logic entering;
    lvl = sel_level(s, d, e);
    entering = (s == 3'd0) && (ps != 3'd0);
    return a & c & lvl & ~pv & ~entering;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s start_conv actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // Apply inputs after a falling edge, check mid-phase, advance model
  task automatic cyc(string tag, logic [2:0] s, logic a, logic c, logic d, logic [6:0] e);
    @(negedge clk);
    src_sel = s; auto_en = a; conv_en = c; conv_done = d; evt_flags = e;
    #5;
    check(tag, start_conv, exp_start(s, a, c, d, e, m_prev, m_psel));
    m_prev = sel_level(s, d, e);
    m_psel = s;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R8: quiet during reset with everything high
    @(negedge clk);
    src_sel = 3'd1; auto_en = 1; conv_en = 1; conv_done = 1; evt_flags = '1;
    #5 check("R8", start_conv, 1'b0);
    @(negedge clk);
    #5 check("R8", start_conv, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    m_prev = 1'b0; m_psel = 3'd0;
    #5;
    // first cycle after reset: source high, history clear -> pulse
    check("R8", start_conv, 1'b1);
    m_prev = 1'b1; m_psel = 3'd1;
    cyc("R2", 3'd1, 1, 1, 0, 7'b000_0001);   // held high: no pulse
    cyc("R2", 3'd1, 1, 1, 0, 7'b000_0000);
    cyc("R2", 3'd1, 1, 1, 0, 7'b000_0001);   // new edge
    // R9: unselected toggling ignored
    cyc("R9", 3'd2, 1, 1, 0, 7'b000_0000);
    cyc("R9", 3'd2, 1, 1, 0, 7'b000_0001);
    cyc("R9", 3'd2, 1, 1, 0, 7'b111_1101);
    // R5: reselect low source -> high source
    cyc("R5", 3'd3, 1, 1, 0, 7'b000_1000);
    cyc("R5", 3'd4, 1, 1, 0, 7'b000_1000);
    // R6: into free running with completion flag high
    cyc("R6", 3'd5, 1, 1, 1, 7'b000_0000);
    cyc("R6", 3'd0, 1, 1, 1, 7'b000_0000);
    cyc("R6", 3'd0, 1, 1, 1, 7'b000_0000);
    // R7: completion edges in free running
    cyc("R7", 3'd0, 1, 1, 0, 7'b000_0000);
    cyc("R7", 3'd0, 1, 1, 1, 7'b000_0000);
    cyc("R7", 3'd0, 1, 1, 0, 7'b000_0000);
    cyc("R7", 3'd0, 1, 1, 1, 7'b000_0000);
    // R3 and R4: edges while an enable is low
    cyc("R3", 3'd0, 0, 1, 0, 7'b000_0000);
    cyc("R3", 3'd0, 0, 1, 1, 7'b000_0000);
    cyc("R4", 3'd0, 1, 0, 0, 7'b000_0000);
    cyc("R4", 3'd0, 1, 0, 1, 7'b000_0000);
    // R1: each event source in turn
    for (int k = 1; k < 8; k++) begin
      cyc("R1", 3'(k), 1, 1, 0, 7'b000_0000);
      cyc("R1", 3'(k), 1, 1, 0, 7'(1 << (k - 1)));
    end
    // Constrained random: mostly enabled, select changes now and then
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] s;
      s = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : src_sel;
      cyc("R2", s, ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) != 0),
          1'($urandom_range(0, 1)), 7'($urandom_range(0, 127)));
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule